// File: doc/BRIEF.md
# Decoupled Tag-Data Pointer Directory

This block is the metadata side of a cache whose tag store has twice as many entries as there are data slots. Any valid tag may map to any data slot through a forward pointer, and every slot keeps a backward pointer to the tag that owns it. Only tags, valid bits and the two pointer arrays are held here. The data array, the refill from the next level and the global replacement policy live elsewhere.

A requester presents an address with a ready/valid handshake, and one request is handled at a time. The block reads the addressed tag set and compares the tags. Later it raises a one-cycle done pulse carrying hit or miss and the data-slot index that the serialized data access should use. A miss takes one of two paths:

- **Full set:** every way is valid. A per-set round-robin pointer picks a way. The new tag overwrites that way and inherits its data slot.
- **Set with a hole:** a data slot is obtained for the lowest invalid way. The block takes the lowest free slot if one exists. Otherwise it asks an external global victim selector for a slot, frees the tag that owned that slot, and relinks both pointers.

Top module: `vway_dir`

## Requirements
- R1: After reset, `req_ready` is 1 and both `done` and `vic_req` are 0. All tags are invalid and all data slots are free.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle in which `done` is high. `done` is a single-cycle pulse.
- R3: On a hit, `done` rises on the second clock edge after acceptance, with `done_hit` = 1 and `done_slot` equal to the matching tag's forward pointer.
- R4: On a miss where the set has an invalid way and a free data slot exists, the lowest-index free slot is linked to the lowest invalid way. `done` rises on the second edge after acceptance with `done_hit` = 0 and that slot index, and the slot is no longer free.
- R5: On a miss to a set whose ways are all valid, the way named by that set's round-robin pointer is overwritten with the new tag. The round-robin pointer advances by one and wraps to way 0 after the last way. The line keeps its old slot, which is reported. `vic_req` is not raised, and the tag that was overwritten misses afterwards.
- R6: On a miss where the set has an invalid way and no slot is free, `vic_req` is 1 from the second edge after acceptance. It stays 1 until an edge that samples `vic_gnt` = 1. That edge raises `done` with `done_hit` = 0 and `done_slot` = `vic_slot`.
- R7: When a slot is reclaimed through the victim selector, the tag named by that slot's backward pointer becomes invalid, so a later lookup of it misses. The new tag hits on the granted slot.
- R8: For every valid tag, the backward pointer of the slot its forward pointer names refers back to that tag.
- R9: Round-robin pointers are kept per set. Local evictions in one set do not move the pointer of another set.
- R10: The address is split with the set index in the low `SET_BITS` bits and the tag in the bits above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | TAG_W+SET_BITS (12) | Line address: set in low bits, tag above |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | 1 on hit, 0 on miss (valid with `done`) |
| done_slot | output | SLOT_W (5) | Data-slot index for the access (valid with `done`) |
| vic_req | output | 1 | Request for a global victim slot |
| vic_gnt | input | 1 | Victim slot supplied |
| vic_slot | input | SLOT_W (5) | Victim slot index, valid with `vic_gnt` |

## Verification
Hits and both locally allocated misses (free slot, round-robin overwrite) complete on the second clock edge after the accepting edge. A reclaim raises `vic_req` on that same second edge and completes on the edge that samples `vic_gnt`. Each directed task samples on falling edges. It checks that the block is busy and `done` is low one half-cycle after acceptance, then checks `done` with its hit flag and slot exactly one cycle later. On the victim path it holds the grant back an extra cycle to confirm that `vic_req` persists, and checks `done` on the falling edge right after the grant is sampled, then confirms the pulse has ended one cycle later.

// File: rtl/vway_pkg.sv
// Package: shared types for the decoupled tag-data pointer directory.
// Assumes nothing beyond IEEE 1800-2017.
package vway_pkg;

    // Controller phases: idle, tag compare, waiting for a global victim slot
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_RECLM  = 2'd2
    } dir_state_e;

endpackage

// File: rtl/vway_tag_match.sv
// Module: vway_tag_match
// Compares one tag set against a lookup tag. Reports a hit and its way,
// and the lowest invalid way of the set.
// Assumes at most one valid way matches (the directory never duplicates a tag).
module vway_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [TAG_W-1:0] set_tag [WAYS],
    input  logic [WAYS-1:0]  set_vld,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic             any_inv,
    output logic [WAY_W-1:0] inv_way
);

    logic [WAYS-1:0] match;

    // Per-way equality against the lookup tag, gated by valid
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_vld[w] && (set_tag[w] == look_tag);
    end

    // Encode the matching way and the lowest invalid way
    always_comb begin
        hit     = |match;
        any_inv = ~&set_vld;
        hit_way = '0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])    hit_way = WAY_W'(w);
            if (!set_vld[w]) inv_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/vway_slot_alloc.sv
// Module: vway_slot_alloc
// Free-slot bitmap with a lowest-index priority encoder. All slots are
// free after reset. A slot leaves the pool when take is pulsed with its index.
// Assumes take is only raised while any_free is 1 and take_idx is free.
module vway_slot_alloc #(
    parameter int NSLOTS = 32,
    localparam int SLOT_W = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [SLOT_W-1:0] take_idx,
    output logic              any_free,
    output logic [SLOT_W-1:0] free_idx
);

    logic [NSLOTS-1:0] free_q;

    // Bitmap update: reset fills the pool, take removes one slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '1;
        end else if (take) begin
            free_q[take_idx] <= 1'b0;
        end
    end

    // Lowest-index free slot
    always_comb begin
        any_free = |free_q;
        free_idx = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (free_q[i]) free_idx = SLOT_W'(i);
        end
    end

endmodule

// File: rtl/vway_dir.sv
// Module: vway_dir
// Tag directory with twice as many tags as data slots. Forward pointers
// link tags to slots and backward pointers link slots to tags. Handles
// lookup, local round-robin replacement in full sets, free-slot
// allocation and reclaim of a globally chosen slot over a req/gnt handshake.
// Assumes WAYS is a power of two and that the victim selector only grants
// slots that are in use, which holds whenever it is asked.
module vway_dir
    import vway_pkg::*;
#(
    parameter int SET_BITS = 4,
    parameter int WAYS     = 4,
    parameter int TAG_W    = 8,
    localparam int NSETS  = 1 << SET_BITS,
    localparam int NTAGS  = NSETS * WAYS,
    localparam int NSLOTS = NTAGS / 2,
    localparam int SLOT_W = $clog2(NSLOTS),
    localparam int ADDR_W = TAG_W + SET_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic              done_hit,
    output logic [SLOT_W-1:0] done_slot,
    output logic              vic_req,
    input  logic              vic_gnt,
    input  logic [SLOT_W-1:0] vic_slot
);

    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TID_W = $clog2(NTAGS);

    // Directory state
    logic [TAG_W-1:0]  tag_q   [NTAGS];
    logic [NTAGS-1:0]  valid_q;
    logic [SLOT_W-1:0] fptr_q  [NTAGS];
    logic [TID_W-1:0]  bptr_q  [NSLOTS];
    logic [WAY_W-1:0]  rr_q    [NSETS];

    dir_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  hole_q;

    // Lookup view
    logic [SET_BITS-1:0] cur_set;
    logic [TAG_W-1:0]    cur_tag;
    logic [TAG_W-1:0]    set_tag [WAYS];
    logic [WAYS-1:0]     set_vld;
    logic                hit;
    logic [WAY_W-1:0]    hit_way;
    logic                any_inv;
    logic [WAY_W-1:0]    inv_way;
    logic                any_free;
    logic [SLOT_W-1:0]   free_idx;
    logic                take;
    logic [TID_W-1:0]    hit_tid, rr_tid, inv_tid, hole_tid, old_tid;

    assign cur_set = addr_q[SET_BITS-1:0];
    assign cur_tag = addr_q[ADDR_W-1:SET_BITS];

    // Gather the addressed set out of the flat tag store
    for (genvar w = 0; w < WAYS; w++) begin : g_view
        assign set_tag[w] = tag_q[{cur_set, WAY_W'(w)}];
        assign set_vld[w] = valid_q[{cur_set, WAY_W'(w)}];
    end

    vway_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tag  (set_tag),
        .set_vld  (set_vld),
        .look_tag (cur_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .any_inv  (any_inv),
        .inv_way  (inv_way)
    );

    // Slot pool is drawn from only on the free-slot miss path
    assign take = (state_q == ST_LOOKUP) && !hit && any_inv && any_free;

    vway_slot_alloc #(.NSLOTS(NSLOTS)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_idx (free_idx),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    // Global tag identifiers for each candidate way
    always_comb begin
        hit_tid  = {cur_set, hit_way};
        rr_tid   = {cur_set, rr_q[cur_set]};
        inv_tid  = {cur_set, inv_way};
        hole_tid = {cur_set, hole_q};
        old_tid  = bptr_q[vic_slot];
    end

    assign req_ready = (state_q == ST_IDLE);
    assign vic_req   = (state_q == ST_RECLM);

    // Controller: accept, compare, allocate or reclaim, and report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            hole_q    <= '0;
            done      <= 1'b0;
            done_hit  <= 1'b0;
            done_slot <= '0;
            valid_q   <= '0;
            for (int t = 0; t < NTAGS; t++) begin
                tag_q[t]  <= '0;
                fptr_q[t] <= '0;
            end
            for (int s = 0; s < NSLOTS; s++) begin
                bptr_q[s] <= '0;
            end
            for (int k = 0; k < NSETS; k++) begin
                rr_q[k] <= '0;
            end
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        done      <= 1'b1;
                        done_hit  <= 1'b1;
                        done_slot <= fptr_q[hit_tid];
                        state_q   <= ST_IDLE;
                    end else if (!any_inv) begin
                        tag_q[rr_tid]  <= cur_tag;
                        rr_q[cur_set]  <= (rr_q[cur_set] == WAY_W'(WAYS - 1))
                                          ? '0 : rr_q[cur_set] + 1'b1;
                        done           <= 1'b1;
                        done_hit       <= 1'b0;
                        done_slot      <= fptr_q[rr_tid];
                        state_q        <= ST_IDLE;
                    end else if (any_free) begin
                        tag_q[inv_tid]   <= cur_tag;
                        valid_q[inv_tid] <= 1'b1;
                        fptr_q[inv_tid]  <= free_idx;
                        bptr_q[free_idx] <= inv_tid;
                        done             <= 1'b1;
                        done_hit         <= 1'b0;
                        done_slot        <= free_idx;
                        state_q          <= ST_IDLE;
                    end else begin
                        hole_q  <= inv_way;
                        state_q <= ST_RECLM;
                    end
                end
                ST_RECLM: begin
                    if (vic_gnt) begin
                        valid_q[old_tid]  <= 1'b0;
                        valid_q[hole_tid] <= 1'b1;
                        tag_q[hole_tid]   <= cur_tag;
                        fptr_q[hole_tid]  <= vic_slot;
                        bptr_q[vic_slot]  <= hole_tid;
                        done              <= 1'b1;
                        done_hit          <= 1'b0;
                        done_slot         <= vic_slot;
                        state_q           <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vway_dir_chk.sv
// Module: vway_dir_chk
// Property checker for vway_dir, attached by the bind below. It observes
// the handshake ports and the pointer arrays.
module vway_dir_chk #(
    parameter int NTAGS  = 64,
    parameter int NSLOTS = 32,
    localparam int SLOT_W = $clog2(NSLOTS),
    localparam int TID_W  = $clog2(NTAGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              vic_req,
    input logic              vic_gnt,
    input logic [NTAGS-1:0]  valid_q,
    input logic [SLOT_W-1:0] fptr_q [NTAGS],
    input logic [TID_W-1:0]  bptr_q [NSLOTS]
);

    // R2: an accepted request makes the block busy on the next cycle
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: completion is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: completion only follows a busy cycle
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!req_ready));

    // R6: a victim request persists until granted
    p_vic_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && !vic_gnt) |=> vic_req);

    // R6: the victim request is never raised with the block idle
    p_vic_not_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |-> !req_ready);

    // R8: forward and backward pointers agree for every valid tag
    for (genvar g = 0; g < NTAGS; g++) begin : g_link
        p_link_mutual_r8: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[g] |-> (bptr_q[fptr_q[g]] == TID_W'(g)));
    end

endmodule

bind vway_dir vway_dir_chk #(.NTAGS(NTAGS), .NSLOTS(NSLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .vic_req   (vic_req),
    .vic_gnt   (vic_gnt),
    .valid_q   (valid_q),
    .fptr_q    (fptr_q),
    .bptr_q    (bptr_q)
);

// File: tb/tb_vway_dir.sv
// Directed bench for vway_dir: one task per scenario, each checking its results.
module tb_vway_dir;

    localparam int SB = 4;
    localparam int TW = 8;
    localparam int AW = TW + SB;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          done;
    logic          done_hit;
    logic [SW-1:0] done_slot;
    logic          vic_req;
    logic          vic_gnt = 1'b0;
    logic [SW-1:0] vic_slot = '0;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vway_dir #(.SET_BITS(SB), .WAYS(4), .TAG_W(TW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .done      (done),
        .done_hit  (done_hit),
        .done_slot (done_slot),
        .vic_req   (vic_req),
        .vic_gnt   (vic_gnt),
        .vic_slot  (vic_slot)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // R10: address = {tag, set}
    function automatic logic [AW-1:0] mk(input int tag, input int set);
        return AW'((tag << SB) | set);
    endfunction

    // One lookup. With use_vic, grant gslot one cycle after vic_req appears.
    task automatic access(input int tag, input int set, input bit exp_hit,
                          input int exp_slot, input bit use_vic, input int gslot,
                          input string rq);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = mk(tag, set);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && !done, "R2", "busy after accept",
            int'({req_ready, done}), 0);
        @(negedge clk);
        if (use_vic) begin
            chk(vic_req && !done, "R6", "vic_req on second edge",
                int'({vic_req, done}), 2);
            @(negedge clk);
            chk(vic_req && !done, "R6", "vic_req held without grant",
                int'({vic_req, done}), 2);
            vic_gnt  = 1'b1;
            vic_slot = SW'(gslot);
            @(negedge clk);
            vic_gnt = 1'b0;
        end else begin
            chk(vic_req == 1'b0, rq, "no victim request", int'(vic_req), 0);
        end
        chk(done == 1'b1, rq, "done timing", int'(done), 1);
        chk(done_hit == exp_hit, rq, "hit flag", int'(done_hit), int'(exp_hit));
        chk(int'(done_slot) == exp_slot, rq, "slot", int'(done_slot), exp_slot);
        @(negedge clk);
        chk(done == 1'b0 && vic_req == 1'b0, "R2", "done is one cycle",
            int'({done, vic_req}), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(vic_req == 1'b0, "R1", "vic_req after reset", int'(vic_req), 0);
    endtask

    // R4: set 0 filled from an empty directory, lowest free slots in order
    task automatic t_fill_set0();
        for (int w = 0; w < 4; w++) access(1 + w, 0, 1'b0, w, 1'b0, 0, "R4");
        access(1, 0, 1'b1, 0, 1'b0, 0, "R3");
        access(4, 0, 1'b1, 3, 1'b0, 0, "R3");
    endtask

    // R5: full set replaces round-robin, keeps slots, loses old tags
    task automatic t_local_evict();
        access(5, 0, 1'b0, 0, 1'b0, 0, "R5");
        access(5, 0, 1'b1, 0, 1'b0, 0, "R5");
        access(1, 0, 1'b0, 1, 1'b0, 0, "R5");
        access(2, 0, 1'b0, 2, 1'b0, 0, "R5");
    endtask

    // R4: sets 1..7 take the remaining 28 slots
    task automatic t_fill_rest();
        for (int s = 1; s < 8; s++)
            for (int w = 0; w < 4; w++)
                access(16 + w, s, 1'b0, 4 + (s - 1) * 4 + w, 1'b0, 0, "R4");
        access(19, 7, 1'b1, 31, 1'b0, 0, "R3");
    endtask

    // R9: set 1 starts at way 0 although set 0 has advanced
    task automatic t_rr_per_set();
        access(32, 1, 1'b0, 4, 1'b0, 0, "R9");
    endtask

    // R6/R7: reclaim through the victim selector
    task automatic t_reclaim();
        access(153, 8, 1'b0, 5, 1'b1, 5, "R6");
        access(153, 8, 1'b1, 5, 1'b0, 0, "R7");
        access(17, 1, 1'b0, 6, 1'b1, 6, "R7");
        access(17, 1, 1'b1, 6, 1'b0, 0, "R8");
        access(18, 1, 1'b0, 7, 1'b1, 7, "R7");
        access(32, 1, 1'b1, 4, 1'b0, 0, "R8");
        access(18, 1, 1'b1, 7, 1'b0, 0, "R8");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_set0();
        t_local_evict();
        t_fill_rest();
        t_rr_per_set();
        t_reclaim();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule